// File: doc/BRIEF.md
# NAND Bad Block Remapper

This block keeps the table that translates logical block numbers into physical block numbers for a small NAND array. It also retires physical blocks that fail, either during start-up scanning or later in service. A client asks for a translation on the lookup port and gets a registered answer one cycle later. When the flash controller finds a failing physical block, it reports that block on the retire port. The remapper then marks the block as bad. If the block held live data, the remapper moves that logical block onto a replacement and reports done, with an error flag when no replacement exists.

The allocation policy is fixed by a parameter. In skip policy, the replacement is the first free physical block found by walking upward from the retired block, wrapping past the top. The walk examines one block per cycle. In spare policy, the replacement is the lowest-numbered free block inside the spare region at the top of the array, and it is chosen in the same cycle. In both policies the user capacity is the total block count minus the spare count. It shrinks only when a logical block is left without a home.

Top module: `bbm_remap`

## Requirements
- R1: After reset, logical block i maps to physical block i for every user block (i < NUM_BLK-NUM_SPARE), spare_count equals NUM_SPARE, capacity equals NUM_BLK-NUM_SPARE, exhausted is 0 and rt_busy is 0.
- R2: A lookup request is answered by lk_ack exactly one cycle later. lk_hit is 1 and lk_pba holds the mapped physical block when the logical number is below the user capacity and still mapped. Otherwise lk_hit is 0 and lk_pba is 0.
- R3: After an in-use block is retired with success, lookups of its logical block return the replacement, and the retired block is never handed out again.
- R4: In skip policy, retiring an in-use block p picks the first free block among p+1, p+2, ... modulo NUM_BLK. rt_done pulses d cycles after the accepting clock edge, where d is the forward distance to that block.
- R5: In spare policy, retiring an in-use block picks the lowest-indexed free block with index at least NUM_BLK-NUM_SPARE. rt_done pulses on the accepting edge.
- R6: Retiring a free block marks it bad, lowers spare_count by one, leaves the map unchanged, and pulses rt_done with rt_err 0 on the accepting edge.
- R7: Retiring a block that is already bad changes nothing and pulses rt_done with rt_err 0 on the accepting edge.
- R8: When no free replacement exists, rt_done comes with rt_err 1. In skip policy this happens NUM_BLK-1 cycles after acceptance, and in spare policy on the accepting edge. The logical block becomes unmapped (lookups miss) and capacity drops by one.
- R9: exhausted is 1 exactly when spare_count is 0. spare_count never rises. capacity changes only on a failed retire.
- R10: A retire request while rt_busy is 1 is ignored.
- R11: No two mapped logical blocks ever share a physical block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_req | input | 1 | Lookup request |
| lk_lba | input | BW | Logical block number to translate |
| lk_ack | output | 1 | Lookup answer valid, one cycle after request |
| lk_hit | output | 1 | Logical block is mapped |
| lk_pba | output | BW | Physical block number (0 on miss) |
| rt_req | input | 1 | Retire request, taken when not busy |
| rt_pba | input | BW | Physical block to retire |
| rt_busy | output | 1 | Skip-policy search in progress |
| rt_done | output | 1 | Retire finished (one-cycle pulse) |
| rt_err | output | 1 | No replacement available, valid with rt_done |
| spare_count | output | BW+1 | Number of free physical blocks |
| capacity | output | BW+1 | Number of mapped logical blocks |
| exhausted | output | 1 | No free block remains |

## Verification
A corrupted block-state entry shows up as the wrong replacement on the very next retire that reaches it. It also shows up as a drift in spare_count on the cycle of the corresponding done pulse. A wrong map entry stays hidden until that logical block is looked up, so the bench sweeps every logical block after each retire, and any duplicate physical number appears within one sweep. The search order of the skip policy is exposed through the exact done latency, so a scan that starts from the wrong block or fails to wrap is caught on the retire that triggers it.

// File: rtl/bbm_pkg.sv
package bbm_pkg;

    typedef enum logic [1:0] {
        BLK_FREE = 2'd0,
        BLK_USED = 2'd1,
        BLK_BAD  = 2'd2
    } blk_state_e;

    typedef enum logic {
        POL_SKIP  = 1'b0,
        POL_SPARE = 1'b1
    } policy_e;

    typedef enum logic {
        FSM_IDLE = 1'b0,
        FSM_SCAN = 1'b1
    } fsm_e;

endpackage

// File: rtl/bbm_free_pick.sv
// Lowest-index free block at or above LO.
module bbm_free_pick
    import bbm_pkg::*;
#(
    parameter int N  = 16,
    parameter int LO = 12,
    parameter int BW = 4
) (
    input  blk_state_e [N-1:0] st,
    output logic               found,
    output logic [BW-1:0]      idx
);

    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (i >= LO && st[i] == BLK_FREE) begin
                found = 1'b1;
                idx   = BW'(i);
            end
        end
    end

endmodule

// File: rtl/bbm_lookup.sv
// Registered translation read port.
module bbm_lookup #(
    parameter int USER = 12,
    parameter int BW   = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req,
    input  logic [BW-1:0]          lba,
    input  logic [USER-1:0][BW-1:0] map,
    input  logic [USER-1:0]        mval,
    output logic                   ack,
    output logic                   hit,
    output logic [BW-1:0]          pba
);

    localparam logic [BW:0] USER_W = (BW + 1)'(USER);

    typedef struct packed {
        logic          ack;
        logic          hit;
        logic [BW-1:0] pba;
    } lk_t;

    lk_t l_d, l_q;

    always_comb begin
        l_d     = '0;
        l_d.ack = req;
        if (req && ({1'b0, lba} < USER_W)) begin
            if (mval[lba]) begin
                l_d.hit = 1'b1;
                l_d.pba = map[lba];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) l_q <= '0;
        else        l_q <= l_d;
    end

    assign ack = l_q.ack;
    assign hit = l_q.hit;
    assign pba = l_q.pba;

endmodule

// File: rtl/bbm_remap.sv
module bbm_remap
    import bbm_pkg::*;
#(
    parameter int      NUM_BLK   = 16,
    parameter int      NUM_SPARE = 4,
    parameter policy_e POLICY    = POL_SKIP,
    localparam int     USER      = NUM_BLK - NUM_SPARE,
    localparam int     BW        = $clog2(NUM_BLK)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lk_req,
    input  logic [BW-1:0] lk_lba,
    output logic          lk_ack,
    output logic          lk_hit,
    output logic [BW-1:0] lk_pba,
    input  logic          rt_req,
    input  logic [BW-1:0] rt_pba,
    output logic          rt_busy,
    output logic          rt_done,
    output logic          rt_err,
    output logic [BW:0]   spare_count,
    output logic [BW:0]   capacity,
    output logic          exhausted
);

    localparam logic [BW:0]   CNT_ONE  = (BW + 1)'(1);
    localparam logic [BW:0]   NBLK_W   = (BW + 1)'(NUM_BLK);
    localparam logic [BW-1:0] PTR_LAST = BW'(NUM_BLK - 1);
    localparam logic [BW-1:0] SCAN_LIM = BW'(NUM_BLK - 2);

    typedef struct packed {
        fsm_e                          fsm;
        logic [BW-1:0]                 ptr;
        logic [BW-1:0]                 cnt;
        logic [BW-1:0]                 cur;
        logic                          done;
        logic                          err;
        logic [BW:0]                   free_cnt;
        logic [BW:0]                   cap;
        logic [USER-1:0][BW-1:0]       map;
        logic [USER-1:0]               mval;
        blk_state_e [NUM_BLK-1:0]      st;
        logic [NUM_BLK-1:0][BW-1:0]    own;
    } regs_t;

    function automatic regs_t init_regs();
        regs_t r;
        r          = '0;
        r.fsm      = FSM_IDLE;
        r.free_cnt = (BW + 1)'(NUM_SPARE);
        r.cap      = (BW + 1)'(USER);
        for (int i = 0; i < USER; i++) begin
            r.map[i]  = BW'(i);
            r.mval[i] = 1'b1;
        end
        for (int i = 0; i < NUM_BLK; i++) begin
            r.st[i]  = (i < USER) ? BLK_USED : BLK_FREE;
            r.own[i] = (i < USER) ? BW'(i) : '0;
        end
        return r;
    endfunction

    regs_t         s_d, s_q;
    logic          pick_found;
    logic [BW-1:0] pick_idx;

    generate
        if (POLICY == POL_SPARE) begin : g_spare
            bbm_free_pick #(
                .N  (NUM_BLK),
                .LO (USER),
                .BW (BW)
            ) u_pick (
                .st    (s_q.st),
                .found (pick_found),
                .idx   (pick_idx)
            );
        end else begin : g_skip
            assign pick_found = 1'b0;
            assign pick_idx   = '0;
        end
    endgenerate

    function automatic logic [BW-1:0] next_ptr(input logic [BW-1:0] p);
        return (p == PTR_LAST) ? '0 : BW'(p + 1'b1);
    endfunction

    always_comb begin
        logic [BW-1:0] lo;
        s_d      = s_q;
        s_d.done = 1'b0;
        s_d.err  = 1'b0;
        lo       = s_q.own[rt_pba];
        case (s_q.fsm)
            FSM_IDLE: begin
                if (rt_req) begin
                    if ({1'b0, rt_pba} >= NBLK_W) begin
                        s_d.done = 1'b1;
                    end else begin
                        case (s_q.st[rt_pba])
                            BLK_FREE: begin
                                s_d.st[rt_pba] = BLK_BAD;
                                s_d.free_cnt   = s_q.free_cnt - CNT_ONE;
                                s_d.done       = 1'b1;
                            end
                            BLK_USED: begin
                                s_d.st[rt_pba] = BLK_BAD;
                                s_d.cur        = lo;
                                if (POLICY == POL_SPARE) begin
                                    s_d.done = 1'b1;
                                    if (pick_found) begin
                                        s_d.map[lo]       = pick_idx;
                                        s_d.st[pick_idx]  = BLK_USED;
                                        s_d.own[pick_idx] = lo;
                                        s_d.free_cnt      = s_q.free_cnt - CNT_ONE;
                                    end else begin
                                        s_d.mval[lo] = 1'b0;
                                        s_d.cap      = s_q.cap - CNT_ONE;
                                        s_d.err      = 1'b1;
                                    end
                                end else begin
                                    s_d.fsm = FSM_SCAN;
                                    s_d.ptr = next_ptr(rt_pba);
                                    s_d.cnt = '0;
                                end
                            end
                            default: s_d.done = 1'b1;
                        endcase
                    end
                end
            end
            FSM_SCAN: begin
                if (s_q.st[s_q.ptr] == BLK_FREE) begin
                    s_d.map[s_q.cur]  = s_q.ptr;
                    s_d.st[s_q.ptr]   = BLK_USED;
                    s_d.own[s_q.ptr]  = s_q.cur;
                    s_d.free_cnt      = s_q.free_cnt - CNT_ONE;
                    s_d.done          = 1'b1;
                    s_d.fsm           = FSM_IDLE;
                end else if (s_q.cnt == SCAN_LIM) begin
                    s_d.mval[s_q.cur] = 1'b0;
                    s_d.cap           = s_q.cap - CNT_ONE;
                    s_d.done          = 1'b1;
                    s_d.err           = 1'b1;
                    s_d.fsm           = FSM_IDLE;
                end else begin
                    s_d.ptr = next_ptr(s_q.ptr);
                    s_d.cnt = BW'(s_q.cnt + 1'b1);
                end
            end
            default: s_d.fsm = FSM_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= init_regs();
        else        s_q <= s_d;
    end

    bbm_lookup #(
        .USER (USER),
        .BW   (BW)
    ) u_lookup (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (lk_req),
        .lba   (lk_lba),
        .map   (s_q.map),
        .mval  (s_q.mval),
        .ack   (lk_ack),
        .hit   (lk_hit),
        .pba   (lk_pba)
    );

    assign rt_busy     = (s_q.fsm == FSM_SCAN);
    assign rt_done     = s_q.done;
    assign rt_err      = s_q.err;
    assign spare_count = s_q.free_cnt;
    assign capacity    = s_q.cap;
    assign exhausted   = (s_q.free_cnt == '0);

endmodule

// File: rtl/bbm_remap_chk.sv
module bbm_remap_chk
    import bbm_pkg::*;
#(
    parameter policy_e POLICY = POL_SKIP,
    parameter int      BW     = 4
) (
    input logic        clk,
    input logic        rst_n,
    input logic        lk_req,
    input logic        lk_ack,
    input logic        rt_req,
    input logic        rt_busy,
    input logic        rt_done,
    input logic        rt_err,
    input logic [BW:0] spare_count,
    input logic [BW:0] capacity
);

    // R2
    lookup_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |=> lk_ack);

    // R2
    ack_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_ack |-> $past(lk_req));

    // R9
    spare_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spare_count <= $past(spare_count));

    // R9
    cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rt_done && rt_err) |-> $stable(capacity));

    // R8
    err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rt_err |-> rt_done);

    // R10
    busy_progress_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rt_busy |=> (rt_busy || rt_done));

    generate
        if (POLICY == POL_SPARE) begin : g_spare_chk
            // R5
            spare_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (rt_req && !rt_busy) |=> rt_done);
        end
    endgenerate

endmodule

bind bbm_remap bbm_remap_chk #(
    .POLICY (POLICY),
    .BW     (BW)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .lk_req      (lk_req),
    .lk_ack      (lk_ack),
    .rt_req      (rt_req),
    .rt_busy     (rt_busy),
    .rt_done     (rt_done),
    .rt_err      (rt_err),
    .spare_count (spare_count),
    .capacity    (capacity)
);

// File: tb/sim_bbm_remap.sv
`timescale 1ns/1ps
module sim_bbm_remap;
    import bbm_pkg::*;

    localparam int N  = 16;
    localparam int S  = 4;
    localparam int U  = N - S;
    localparam int BW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic          sel = 1'b0;
    logic          mon_en = 1'b0;
    logic          lk_req = 1'b0;
    logic [BW-1:0] lk_lba = '0;
    logic          rt_req = 1'b0;
    logic [BW-1:0] rt_pba = '0;

    logic          ack0, hit0, busy0, done0, err0, exh0;
    logic [BW-1:0] pba0;
    logic [BW:0]   spc0, cap0;
    logic          ack1, hit1, busy1, done1, err1, exh1;
    logic [BW-1:0] pba1;
    logic [BW:0]   spc1, cap1;

    bbm_remap #(.NUM_BLK(N), .NUM_SPARE(S), .POLICY(POL_SKIP)) u0 (
        .clk(clk), .rst_n(rst_n),
        .lk_req(lk_req & ~sel), .lk_lba(lk_lba),
        .lk_ack(ack0), .lk_hit(hit0), .lk_pba(pba0),
        .rt_req(rt_req & ~sel), .rt_pba(rt_pba),
        .rt_busy(busy0), .rt_done(done0), .rt_err(err0),
        .spare_count(spc0), .capacity(cap0), .exhausted(exh0)
    );

    bbm_remap #(.NUM_BLK(N), .NUM_SPARE(S), .POLICY(POL_SPARE)) u1 (
        .clk(clk), .rst_n(rst_n),
        .lk_req(lk_req & sel), .lk_lba(lk_lba),
        .lk_ack(ack1), .lk_hit(hit1), .lk_pba(pba1),
        .rt_req(rt_req & sel), .rt_pba(rt_pba),
        .rt_busy(busy1), .rt_done(done1), .rt_err(err1),
        .spare_count(spc1), .capacity(cap1), .exhausted(exh1)
    );

    wire          ack  = sel ? ack1  : ack0;
    wire          hit  = sel ? hit1  : hit0;
    wire [BW-1:0] pba  = sel ? pba1  : pba0;
    wire          busy = sel ? busy1 : busy0;
    wire          done = sel ? done1 : done0;
    wire          err  = sel ? err1  : err0;
    wire [BW:0]   spc  = sel ? spc1  : spc0;
    wire [BW:0]   cap  = sel ? cap1  : cap0;
    wire          exh  = sel ? exh1  : exh0;

    // behavioural reference: 0 free, 1 in use, 2 bad
    int mmap[U];
    bit mval[U];
    int mst[N];
    int mown[N];
    int mfree, mcap;
    int nchk = 0, nfail = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < U; i++) begin mmap[i] = i; mval[i] = 1'b1; end
        for (int i = 0; i < N; i++) begin
            mst[i]  = (i < U) ? 1 : 0;
            mown[i] = (i < U) ? i : 0;
        end
        mfree = S;
        mcap  = U;
    endtask

    always @(posedge clk) begin
        #5;
        if (mon_en) begin
            chk(int'(spc) == mfree, "R9 spare_count", int'(spc), mfree);
            chk(int'(cap) == mcap, "R9 capacity", int'(cap), mcap);
            chk(exh == (mfree == 0), "R9 exhausted", int'(exh), int'(mfree == 0));
        end
    end

    task automatic lookup(input int l, output int pb, output bit h);
        bit eh;
        int ep;
        @(posedge clk); #1;
        lk_req = 1'b1; lk_lba = BW'(l);
        @(posedge clk); #1;
        lk_req = 1'b0;
        eh = (l < U) && mval[l];
        ep = eh ? mmap[l] : 0;
        chk(ack == 1'b1, "R2 ack", int'(ack), 1);
        chk(hit == eh, "R2 hit", int'(hit), int'(eh));
        chk(int'(pba) == ep, "R3 mapped block", int'(pba), ep);
        pb = int'(pba);
        h  = hit;
    endtask

    task automatic check_all();
        bit [N-1:0] seen = '0;
        int pb;
        bit h;
        for (int l = 0; l < U; l++) begin
            lookup(l, pb, h);
            if (h) begin
                chk(!seen[pb], "R11 shared physical block", pb, -1);
                seen[pb] = 1'b1;
            end
        end
    endtask

    task automatic do_retire(input int p, input bit inject, input int inj_pba);
        int kind, tgt, lo, lat_e, lat;
        bit err_e;
        string tag;
        kind = mst[p]; tgt = -1; lo = 0; lat_e = 0; err_e = 1'b0;
        if (kind == 1) begin
            lo = mown[p];
            err_e = 1'b1;
            if (!sel) begin
                lat_e = N - 1;
                for (int d = 1; d < N; d++) begin
                    if (mst[(p + d) % N] == 0) begin
                        tgt = (p + d) % N; lat_e = d; err_e = 1'b0; break;
                    end
                end
            end else begin
                for (int i = U; i < N; i++) begin
                    if (mst[i] == 0) begin tgt = i; err_e = 1'b0; break; end
                end
            end
        end
        if (kind == 0)      tag = "R6";
        else if (kind == 2) tag = "R7";
        else if (err_e)     tag = "R8";
        else                tag = sel ? "R5" : "R4";

        @(posedge clk); #1;
        rt_req = 1'b1; rt_pba = BW'(p);
        @(posedge clk); #1;
        rt_req = 1'b0;
        lat = 0;
        while (!done && lat < N + 4) begin
            if (inject && lat == 0) begin rt_req = 1'b1; rt_pba = BW'(inj_pba); end
            @(posedge clk); #1;
            rt_req = 1'b0;
            lat++;
        end
        chk(done == 1'b1, {tag, " done"}, int'(done), 1);
        chk(lat == lat_e, {tag, " latency"}, lat, lat_e);
        chk(err == err_e, {tag, " err"}, int'(err), int'(err_e));

        if (kind == 0) begin
            mst[p] = 2; mfree--;
        end else if (kind == 1) begin
            mst[p] = 2;
            if (tgt >= 0) begin
                mmap[lo] = tgt; mst[tgt] = 1; mown[tgt] = lo; mfree--;
            end else begin
                mval[lo] = 1'b0; mcap--;
            end
        end
    endtask

    task automatic run_policy(input bit s);
        int pb;
        bit h;
        mon_en = 1'b0;
        sel = s;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        model_reset();
        #1 rst_n = 1'b1;
        @(posedge clk); #6;
        // R1 reset state
        chk(int'(spc) == S, "R1 spare_count", int'(spc), S);
        chk(int'(cap) == U, "R1 capacity", int'(cap), U);
        chk(exh == 1'b0, "R1 exhausted", int'(exh), 0);
        chk(busy == 1'b0, "R1 busy", int'(busy), 0);
        mon_en = 1'b1;
        for (int l = 0; l < U; l++) begin
            lookup(l, pb, h);
            chk(pb == l && h, "R1 identity map", pb, l);
        end
        lookup(U + 1, pb, h);
        chk(!h, "R2 out-of-range miss", int'(h), 0);

        do_retire(14, 1'b0, 0);
        do_retire(14, 1'b0, 0);
        do_retire(3, 1'b0, 0);
        lookup(3, pb, h);
        chk(pb == 12, "R3 replacement", pb, 12);
        if (!s) begin
            // R10: pulse a retire of free block 15 during the scan
            do_retire(11, 1'b1, 15);
            chk(int'(spc) == 1, "R10 ignored retire", int'(spc), 1);
        end else begin
            do_retire(11, 1'b0, 0);
        end
        check_all();

        for (int k = 0; k < 20; k++) begin
            do_retire(int'($urandom_range(0, N - 1)), 1'b0, 0);
            check_all();
        end
        for (int p = 0; p < N; p++) begin
            if (mst[p] == 0) do_retire(p, 1'b0, 0);
        end
        for (int l = 0; l < U; l++) begin
            if (mval[l]) begin
                do_retire(mmap[l], 1'b0, 0);
                lookup(l, pb, h);
                chk(!h, "R8 unmapped after failure", int'(h), 0);
                break;
            end
        end
        chk(exh == 1'b1, "R9 exhausted at end", int'(exh), 1);
        check_all();
        mon_en = 1'b0;
    endtask

    initial begin
        #(8 * 150000);
        nfail++;
        $display("FAIL watchdog all actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        run_policy(1'b0);
        run_policy(1'b1);
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

endmodule